// File: doc/BRIEF.md
# Predicated Vector Multiply-Add Sequencer with Twin Writeback

This block steps through the element operations of one vector multiply-add instruction. A start pulse captures the vector length, the maximum vector length, a predicate mask, one vector-or-scalar flag for each of the three sources and the destination, and the source and destination element widths. While it runs, it sends three source element indices to an external register file and receives the three element values in the same cycle. It computes `a*b + c` and writes the result as two halves through two write ports in that same cycle.

Only elements whose predicate bit is set are processed. Each such element takes exactly one cycle, and inactive elements cost nothing. The low half of the result goes to destination element index `d`. The high half goes to element index `d+MAXVL`, counted from the same destination base. An index advances only for an operand flagged as a vector, and a scalar destination finishes the sequence after its first write. A one-cycle `done` pulse closes every sequence, including one that makes no writes.

Top module: `vmadd_seq`

## Requirements
- R1: When `start` is high while the block is idle, it samples `vl` (1..64), `maxvl` (1..64, not less than `vl`), `pred`, the four vector flags and both width codes. A width code of 0, 1, 2 or 3 means 8, 16, 32 or 64 bits.
- R2: Element i is active only when i < `vl` and bit i of `pred` is set. Active elements are processed in ascending order, one per cycle, in consecutive cycles starting the cycle after `start` is sampled. Each active element raises `wr_en` for exactly that cycle.
- R3: Each source index starts at 0. After every active element it increases by 1 if that source's vector flag is set, and stays at 0 if the flag is clear.
- R4: The destination index `wr_lo_idx` starts at 0 and increases by 1 after each active element when `vec_d` is set. When `vec_d` is clear, the sequence ends after its first write.
- R5: Each source value is the low source-width bits of its read data. Higher bits are ignored.
- R6: The result is the unsigned value a*b + c. `wr_lo_data` carries bits [dw-1:0] of the result, where dw is the destination width, zero-extended. `wr_w` shows the destination width code.
- R7: `wr_hi_data` carries result bits [2dw-1:dw], zero-extended. It is written at element index `wr_hi_idx` = destination index + `maxvl`.
- R8: `done` is high for one cycle, in the cycle after the last write. If no element is active, it is high in the cycle after `start` is sampled and no write occurs.
- R9: A `start` pulse while a sequence is running is ignored. The running sequence and its writes are unaffected, and it produces no extra sequence or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| vl | input | 7 | Vector length |
| maxvl | input | 7 | Maximum vector length, offset of high-half elements |
| pred | input | 64 | Predicate mask, bit i enables element i |
| vec_a | input | 1 | Source a is a vector |
| vec_b | input | 1 | Source b is a vector |
| vec_c | input | 1 | Source c (addend) is a vector |
| vec_d | input | 1 | Destination is a vector |
| src_w | input | 2 | Source width code |
| dst_w | input | 2 | Destination width code |
| rd_idx_a | output | 6 | Element index for source a |
| rd_idx_b | output | 6 | Element index for source b |
| rd_idx_c | output | 6 | Element index for source c |
| rd_data_a | input | 64 | Read data for source a |
| rd_data_b | input | 64 | Read data for source b |
| rd_data_c | input | 64 | Read data for source c |
| wr_en | output | 1 | Both write ports active this cycle |
| wr_w | output | 2 | Destination width code for both writes |
| wr_lo_idx | output | 6 | Element index of the low half |
| wr_lo_data | output | 64 | Low half of the result |
| wr_hi_idx | output | 7 | Element index of the high half |
| wr_hi_data | output | 64 | High half of the result |
| done | output | 1 | Sequence finished |

## Verification
The assertions assume that `vl` and `maxvl` lie in 1..64 with `vl` no greater than `maxvl`. They also assume that read data comes back combinationally in the cycle its index is presented, so that a cycle with `wr_en` high holds one complete element. The stimulus draws every configuration from those ranges. A bench-side register file model answers reads from the indices alone. Predicates include empty masks, masks whose set bits all lie at or above `vl`, a full 64-element run, and a second `start` sent in the middle of a run.

// File: rtl/vmadd_seq.sv
module vmadd_seq #(
  parameter int XLEN = 64,
  parameter int MAXE = 64,
  localparam int IW = $clog2(MAXE),
  localparam int LW = IW + 1,
  localparam int PW = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LW-1:0]   vl,
  input  logic [LW-1:0]   maxvl,
  input  logic [MAXE-1:0] pred,
  input  logic            vec_a,
  input  logic            vec_b,
  input  logic            vec_c,
  input  logic            vec_d,
  input  logic [1:0]      src_w,
  input  logic [1:0]      dst_w,
  output logic [IW-1:0]   rd_idx_a,
  output logic [IW-1:0]   rd_idx_b,
  output logic [IW-1:0]   rd_idx_c,
  input  logic [XLEN-1:0] rd_data_a,
  input  logic [XLEN-1:0] rd_data_b,
  input  logic [XLEN-1:0] rd_data_c,
  output logic            wr_en,
  output logic [1:0]      wr_w,
  output logic [IW-1:0]   wr_lo_idx,
  output logic [XLEN-1:0] wr_lo_data,
  output logic [LW-1:0]   wr_hi_idx,
  output logic [XLEN-1:0] wr_hi_data,
  output logic            done
);

  logic            run_q, done_q;
  logic [MAXE-1:0] pend_q, pend_nx, vl_mask, pend_init;
  logic [IW-1:0]   ia_q, ib_q, ic_q, id_q;
  logic            va_q, vb_q, vc_q, vd_q;
  logic [1:0]      sw_q, dw_q;
  logic [LW-1:0]   maxvl_q;
  logic            last;

  always_comb begin
    for (int k = 0; k < MAXE; k++)
      vl_mask[k] = (LW'(k) < vl);
  end

  assign pend_init = pred & vl_mask;
  assign pend_nx   = pend_q & (pend_q - 1'b1);
  assign last      = (pend_nx == '0) || !vd_q;

  logic [7:0]      sbits, dbits;
  logic [XLEN-1:0] smask, dmask, opa, opb, opc;
  logic [PW-1:0]   res;

  assign sbits = 8'd8 << sw_q;
  assign dbits = 8'd8 << dw_q;
  assign smask = {XLEN{1'b1}} >> (XLEN - int'(sbits));
  assign dmask = {XLEN{1'b1}} >> (XLEN - int'(dbits));
  assign opa   = rd_data_a & smask;
  assign opb   = rd_data_b & smask;
  assign opc   = rd_data_c & smask;
  assign res   = PW'(opa) * PW'(opb) + PW'(opc);

  assign rd_idx_a   = ia_q;
  assign rd_idx_b   = ib_q;
  assign rd_idx_c   = ic_q;
  assign wr_en      = run_q;
  assign wr_w       = dw_q;
  assign wr_lo_idx  = id_q;
  assign wr_hi_idx  = LW'(id_q) + maxvl_q;
  assign wr_lo_data = res[XLEN-1:0] & dmask;
  assign wr_hi_data = XLEN'(res >> dbits) & dmask;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      ia_q    <= '0;
      ib_q    <= '0;
      ic_q    <= '0;
      id_q    <= '0;
      va_q    <= 1'b0;
      vb_q    <= 1'b0;
      vc_q    <= 1'b0;
      vd_q    <= 1'b0;
      sw_q    <= '0;
      dw_q    <= '0;
      maxvl_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (run_q) begin
        pend_q <= pend_nx;
        if (va_q) ia_q <= ia_q + 1'b1;
        if (vb_q) ib_q <= ib_q + 1'b1;
        if (vc_q) ic_q <= ic_q + 1'b1;
        if (vd_q) id_q <= id_q + 1'b1;
        if (last) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        pend_q  <= pend_init;
        ia_q    <= '0;
        ib_q    <= '0;
        ic_q    <= '0;
        id_q    <= '0;
        va_q    <= vec_a;
        vb_q    <= vec_b;
        vc_q    <= vec_c;
        vd_q    <= vec_d;
        sw_q    <= src_w;
        dw_q    <= dst_w;
        maxvl_q <= maxvl;
        if (pend_init == '0) done_q <= 1'b1;
        else                 run_q  <= 1'b1;
      end
    end
  end

  a_r4_scalar_dest_once: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !vd_q |=> !wr_en);

  a_r3_vec_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) && va_q |-> rd_idx_a == $past(rd_idx_a) + 1'b1);

  a_r6_lo_fits_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_lo_data >> (8 << wr_w)) == '0);

  a_r7_hi_fits_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_hi_data >> (8 << wr_w)) == '0);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> done);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && start |=> !wr_en || wr_w == $past(wr_w));

endmodule

// File: tb/vmadd_seq_tb.sv
module vmadd_seq_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = 7'd1, maxvl = 7'd1;
  logic [63:0] pred = '0;
  logic        vec_a = 1'b0, vec_b = 1'b0, vec_c = 1'b0, vec_d = 1'b0;
  logic [1:0]  src_w = '0, dst_w = '0;
  logic [5:0]  rd_idx_a, rd_idx_b, rd_idx_c;
  logic [63:0] rd_data_a, rd_data_b, rd_data_c;
  logic        wr_en, done;
  logic [1:0]  wr_w;
  logic [5:0]  wr_lo_idx;
  logic [6:0]  wr_hi_idx;
  logic [63:0] wr_lo_data, wr_hi_data;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] fa(input logic [5:0] i);
    return 64'hF1E2D3C4B5A69788 ^ ({58'd0, i} * 64'h9E3779B97F4A7C15);
  endfunction
  function automatic logic [63:0] fb(input logic [5:0] i);
    return 64'h0FEDCBA987654321 + ({58'd0, i} * 64'hC2B2AE3D27D4EB4F);
  endfunction
  function automatic logic [63:0] fc(input logic [5:0] i);
    return 64'hFFFF0000FFFF0000 ^ ({58'd0, i} * 64'h165667B19E3779F9);
  endfunction

  assign rd_data_a = fa(rd_idx_a);
  assign rd_data_b = fb(rd_idx_b);
  assign rd_data_c = fc(rd_idx_c);

  vmadd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .maxvl(maxvl), .pred(pred),
    .vec_a(vec_a), .vec_b(vec_b), .vec_c(vec_c), .vec_d(vec_d),
    .src_w(src_w), .dst_w(dst_w),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .rd_idx_c(rd_idx_c),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c),
    .wr_en(wr_en), .wr_w(wr_w), .wr_lo_idx(wr_lo_idx), .wr_lo_data(wr_lo_data),
    .wr_hi_idx(wr_hi_idx), .wr_hi_data(wr_hi_data), .done(done)
  );

  typedef struct {
    logic [5:0]  ia, ib, ic, lidx;
    logic [6:0]  hidx;
    logic [1:0]  w;
    logic [63:0] lo, hi;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (q.size() == 0) begin
        chk(0, "R2", "unexpected write", {57'd0, wr_hi_idx}, 64'd0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(rd_idx_a == e.ia && rd_idx_b == e.ib && rd_idx_c == e.ic, "R3", "source indices",
            {46'd0, rd_idx_a, rd_idx_b, rd_idx_c}, {46'd0, e.ia, e.ib, e.ic});
        chk(wr_lo_idx == e.lidx, "R4", "low index", {58'd0, wr_lo_idx}, {58'd0, e.lidx});
        chk(wr_lo_data == e.lo && wr_w == e.w, "R6", "low data", wr_lo_data, e.lo);
        chk(wr_hi_idx == e.hidx, "R7", "high index", {57'd0, wr_hi_idx}, {57'd0, e.hidx});
        chk(wr_hi_data == e.hi, "R7", "high data", wr_hi_data, e.hi);
      end
    end
  end

  task automatic run(input int nvl, input int nmax, input logic [63:0] p,
                     input bit a, input bit b, input bit c, input bit d,
                     input int sw, input int dw, input bit poke);
    int n = 0, s_cyc, ia = 0, ib = 0, ic = 0, id = 0;
    int sb = 8 << sw, db = 8 << dw;
    logic [63:0] sm, dm;
    sm = {64{1'b1}} >> (64 - sb);
    dm = {64{1'b1}} >> (64 - db);
    for (int i = 0; i < nvl; i++) begin
      if (p[i]) begin
        item_t e;
        logic [127:0] r;
        r = {64'd0, fa(6'(ia)) & sm} * {64'd0, fb(6'(ib)) & sm} + {64'd0, fc(6'(ic)) & sm};
        e.ia = 6'(ia); e.ib = 6'(ib); e.ic = 6'(ic);
        e.lidx = 6'(id); e.hidx = 7'(id + nmax); e.w = 2'(dw);
        e.lo = r[63:0] & dm;
        e.hi = 64'(r >> db) & dm;
        q.push_back(e);
        n++;
        if (!d) break;
        if (a) ia++;
        if (b) ib++;
        if (c) ic++;
        id++;
      end
    end
    @(negedge clk);
    vl = 7'(nvl); maxvl = 7'(nmax); pred = p;
    vec_a = a; vec_b = b; vec_c = c; vec_d = d;
    src_w = 2'(sw); dst_w = 2'(dw); start = 1'b1;
    @(posedge clk);
    #1 s_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke && n > 2) begin
      // R9: second start mid-run with a different setup
      @(negedge clk);
      vl = 7'd3; maxvl = 7'd3; pred = '1; vec_d = 1'b0;
      dst_w = 2'(3 - dw); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    begin
      int t = 0;
      while (!done && t < 500) begin
        if (cyc != s_cyc || t > 0) ;
        @(negedge clk);
        t++;
        if (done) break;
      end
      if (t == 0 && done) ;
    end
    chk(done == 1'b1, "R8", "done seen", {63'd0, done}, 64'd1);
    chk(cyc == s_cyc + n, "R2", "cycles to done", 64'(cyc), 64'(s_cyc + n));
    chk(q.size() == 0, "R2", "writes outstanding", 64'(q.size()), 64'd0);
    q.delete();
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", {63'd0, done}, 64'd0);
    repeat (3) begin
      @(negedge clk);
      chk(!done && !wr_en, "R9", "quiet after sequence", {62'd0, done, wr_en}, 64'd0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !done, "R1", "reset idle", {62'd0, wr_en, done}, 64'd0);
    // R1 R2 R6 R7: full vector, 64-bit widths
    run(8, 8, 64'hFF, 1, 1, 1, 1, 3, 3, 0);
    // R3 R5: sparse predicate, mixed flags, narrow source
    run(10, 16, 64'h2A5, 1, 0, 1, 1, 1, 2, 0);
    // R4: scalar destination stops after first active element
    run(12, 20, 64'hFF8, 1, 1, 1, 0, 2, 2, 0);
    // R7: full length, high index reaches 127
    run(64, 64, '1, 1, 1, 1, 1, 0, 0, 0);
    // R8: empty predicate
    run(16, 32, 64'd0, 1, 1, 1, 1, 0, 0, 0);
    // R2 R8: set bits only at or above vl
    run(5, 9, 64'hFFE0, 1, 1, 1, 1, 1, 1, 0);
    // R5 R6: wide sources, 8-bit destination
    run(6, 40, 64'h3B, 0, 1, 0, 1, 3, 0, 0);
    // R9: start while running
    run(9, 12, 64'h1DB, 1, 1, 0, 1, 2, 1, 1);
    // R2: single element
    run(1, 1, 64'h1, 1, 1, 1, 1, 3, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule